// File: doc/BRIEF.md
# Five-Level Staircase Gate Sequencer for Three Inverter Legs

This block drives the eight switches of each of three diode-clamped inverter legs with a fundamental-frequency staircase pattern. No carrier comparison is involved. A programmable clock divider sets the length of each angular segment. A segment counter walks through one output period. A fixed pattern maps each segment to a pole level, and each level to the on/off state of every switch. As a result, the pole voltage climbs and falls one level at a time, which approximates a sine.

A mode input picks between two staircases. The five-level staircase has twelve 30° segments and eight switches per leg. The three-level staircase has six 60° segments and four switches per leg. The second leg follows the first by one third of the period, and the third leg follows it by two thirds. When the enable input is low, every switch is held off. The sequence starts again at segment 0 when enable returns.

Top module: `stairs_seq`

## Requirements
- R1: During and straight after reset, all 24 gate outputs are 0.
- R2: At every clock edge where `en` is low, all gate outputs of all three legs go to 0 at that edge.
- R3: At the first edge where `en` is high after it was low (or after reset), the legs show the pattern of segment 0 (after each leg's offset). For leg A this is segment 0 itself.
- R4: Each segment lasts `div_val`+1 clock cycles. The segment advances at the edge where its internal count has reached `div_val` or more, and it wraps from the last segment back to 0.
- R5: In five-level mode (`five_lvl`=1), the level for segments 0 to 11 is 1,2,3,4,4,4,3,2,1,0,0,0. Gate bit j (j=0..3) is on when level ≥ 4−j, and bit j+4 is the inverse of bit j.
- R6: In three-level mode (`five_lvl`=0), the level for segments 0 to 5 is 1,2,2,1,0,0. Bit j (j=0..1) is on when level ≥ 2−j, bit j+2 is the inverse of bit j, and bits 7:4 stay 0.
- R7: While a leg is active, exactly half of its switches are on (4 of 8, or 2 of 4), and each upper switch is the complement of its partner.
- R8: In three-level mode, bits 0 and 1 are never on together with bits 2 and 3.
- R9: Between two consecutive active cycles in the same mode, the number of upper switches that are on changes by at most one.
- R10: Leg B shows leg A's pattern delayed by M/3 segments, and leg C shows it delayed by 2M/3 segments, where M is 12 or 6. At segment s, leg B uses pattern (s−M/3) mod M.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low forces all switches off |
| five_lvl | input | 1 | 1 = five-level staircase, 0 = three-level; change only while `en` is low |
| div_val | input | DIV_W | Segment length minus one, in clock cycles |
| gate_a | output | 8 | Switch states of leg A |
| gate_b | output | 8 | Switch states of leg B (lags A by 120°) |
| gate_c | output | 8 | Switch states of leg C (lags A by 240°) |

## Verification
The bound checker checks these properties on every cycle:
- every switch is forced off when the block is disabled;
- half the switches are on and partners are complementary;
- the three-level leg never closes both halves at once;
- the level moves by at most one step between cycles;
- the upper bits stay silent in three-level mode.

Other behaviour can only be shown by the bench scenarios, which compare each cycle against a reference model. This covers the exact staircase order, the dwell of `div_val`+1 cycles per segment, the restart at segment 0 after enable rises, and the 120° and 240° leg offsets.

// File: rtl/stairs_pkg.sv
package stairs_pkg;

    localparam int unsigned LEGS  = 3;
    localparam int unsigned SW_W  = 8;
    localparam int unsigned HALF5 = SW_W / 2;
    localparam int unsigned SEGS5 = 3 * HALF5;
    localparam int unsigned HALF3 = 2;
    localparam int unsigned SEGS3 = 3 * HALF3;
    localparam int unsigned SEG_W = $clog2(SEGS5);

    typedef logic [SEG_W-1:0] seg_t;
    typedef logic [SW_W-1:0]  gate_t;

    // segments in one output period for the selected staircase
    function automatic int unsigned seg_total(input logic five);
        return five ? SEGS5 : SEGS3;
    endfunction

    // upper switches per leg for the selected staircase
    function automatic int unsigned half_sw(input logic five);
        return five ? HALF5 : HALF3;
    endfunction

    // pole level (count of upper switches closed) in a segment
    function automatic int unsigned stair_level(input seg_t s, input logic five);
        int unsigned h;
        int unsigned m;
        int unsigned si;
        h  = half_sw(five);
        m  = seg_total(five);
        si = 32'(s);
        if (si < h)              return si + 1;
        else if (si < m / 2)     return h;
        else if (si < m / 2 + h) return h - 1 - (si - m / 2);
        else                     return 0;
    endfunction

    // switch states of one leg in a segment
    function automatic gate_t leg_gates(input seg_t s, input logic five);
        gate_t       g;
        int unsigned h;
        int unsigned lvl;
        logic        up;
        g   = '0;
        h   = half_sw(five);
        lvl = stair_level(s, five);
        for (int unsigned j = 0; j < HALF5; j++) begin
            if (j < h) begin
                up       = (lvl >= (h - j));
                g[j]     = up;
                g[j + h] = ~up;
            end
        end
        return g;
    endfunction

endpackage

// File: rtl/stairs_phase_ctr.sv
module stairs_phase_ctr
    import stairs_pkg::*;
#(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             five_lvl,
    input  logic [DIV_W-1:0] div_val,
    output seg_t             seg_nxt,
    output logic             run_nxt
);

    typedef struct packed {
        logic             run;
        logic [DIV_W-1:0] cnt;
        seg_t             seg;
    } ctr_t;

    ctr_t ctr_d, ctr_q;
    seg_t seg_last;

    always_comb begin
        seg_last = seg_t'(seg_total(five_lvl) - 1);
        ctr_d    = ctr_q;
        if (!en) begin
            ctr_d = '0;
        end else if (!ctr_q.run) begin
            ctr_d.run = 1'b1;
            ctr_d.cnt = '0;
            ctr_d.seg = '0;
        end else if (ctr_q.cnt >= div_val) begin
            ctr_d.cnt = '0;
            ctr_d.seg = (ctr_q.seg >= seg_last) ? '0 : ctr_q.seg + seg_t'(1);
        end else begin
            ctr_d.cnt = ctr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctr_q <= '0;
        else        ctr_q <= ctr_d;
    end

    assign seg_nxt = ctr_d.seg;
    assign run_nxt = ctr_d.run;

endmodule

// File: rtl/stairs_leg_map.sv
module stairs_leg_map
    import stairs_pkg::*;
#(
    parameter int unsigned LEG_IDX = 0
) (
    input  seg_t  seg,
    input  logic  five_lvl,
    output gate_t gates
);

    int unsigned m;
    int unsigned shift;
    int unsigned rot;

    always_comb begin
        m     = seg_total(five_lvl);
        shift = LEG_IDX * m / LEGS;
        rot   = (32'(seg) + m - shift) % m;
        gates = leg_gates(seg_t'(rot), five_lvl);
    end

endmodule

// File: rtl/stairs_seq.sv
module stairs_seq
    import stairs_pkg::*;
#(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             five_lvl,
    input  logic [DIV_W-1:0] div_val,
    output logic [7:0]       gate_a,
    output logic [7:0]       gate_b,
    output logic [7:0]       gate_c
);

    typedef struct packed {
        gate_t [LEGS-1:0] g;
    } out_t;

    seg_t  seg_nxt;
    logic  run_nxt;
    gate_t map_g [LEGS];
    out_t  out_d, out_q;

    stairs_phase_ctr #(.DIV_W(DIV_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .five_lvl (five_lvl),
        .div_val  (div_val),
        .seg_nxt  (seg_nxt),
        .run_nxt  (run_nxt)
    );

    for (genvar i = 0; i < LEGS; i++) begin : g_leg
        stairs_leg_map #(.LEG_IDX(i)) u_map (
            .seg      (seg_nxt),
            .five_lvl (five_lvl),
            .gates    (map_g[i])
        );
    end

    always_comb begin
        out_d = '0;
        for (int i = 0; i < LEGS; i++) begin
            out_d.g[i] = run_nxt ? map_g[i] : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign gate_a = out_q.g[0];
    assign gate_b = out_q.g[1];
    assign gate_c = out_q.g[2];

endmodule

// File: rtl/stairs_seq_chk.sv
module stairs_seq_chk #(
    parameter int unsigned DIV_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             five_lvl,
    input logic [DIV_W-1:0] div_val,
    input logic [7:0]       gate_a,
    input logic [7:0]       gate_b,
    input logic [7:0]       gate_c
);

    int lvl_a;
    int half_n;

    always_comb begin
        half_n = five_lvl ? 4 : 2;
        lvl_a  = five_lvl ? $countones(gate_a[3:0]) : $countones(gate_a[1:0]);
    end

    // R2: disabled edge leaves every switch open
    p_all_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (gate_a == 8'h00 && gate_b == 8'h00 && gate_c == 8'h00));

    // R7: half the switches closed on an active leg
    p_half_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_a != 8'h00) |-> ($countones(gate_a) == half_n));

    // R7: partner switches complementary in five-level mode
    p_complement_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_a != 8'h00 && five_lvl) |-> (gate_a[3:0] == ~gate_a[7:4]));

    // R6: upper nibble silent in three-level mode
    p_upper_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !five_lvl |-> (gate_a[7:4] == 4'h0 && gate_b[7:4] == 4'h0 && gate_c[7:4] == 4'h0));

    // R8: no leg closes both halves in three-level mode
    p_no_shoot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !five_lvl |-> !(&gate_a[3:0] || &gate_b[3:0] || &gate_c[3:0]));

    // R9: one level step at a time
    p_one_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_a != 8'h00 && $past(gate_a) != 8'h00 && $stable(five_lvl))
        |-> (lvl_a - $past(lvl_a) <= 1 && $past(lvl_a) - lvl_a <= 1));

endmodule

bind stairs_seq stairs_seq_chk #(.DIV_W(DIV_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .five_lvl (five_lvl),
    .div_val  (div_val),
    .gate_a   (gate_a),
    .gate_b   (gate_b),
    .gate_c   (gate_c)
);

// File: tb/tb_stairs_seq.sv
`timescale 1ns/1ps
module tb_stairs_seq;

    localparam int DIV_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b0;
    logic             five_lvl = 1'b1;
    logic [DIV_W-1:0] div_val = '0;
    logic [7:0]       gate_a, gate_b, gate_c;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    bit live = 0;

    // reference model state
    bit m_run = 0;
    int m_cnt = 0;
    int m_seg = 0;
    bit m_restart = 0;
    bit m_step = 0;
    int prev_lvl = -1;

    always #2 clk = ~clk;

    stairs_seq #(.DIV_W(DIV_W)) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .five_lvl(five_lvl),
        .div_val(div_val), .gate_a(gate_a), .gate_b(gate_b), .gate_c(gate_c)
    );

    // expected pattern: each switch is a contiguous window of segments
    function automatic logic [7:0] exp_pat(input int s, input bit five);
        logic [7:0] g;
        int h, m, start, len;
        g = '0;
        h = five ? 4 : 2;
        m = 3 * h;
        for (int j = 0; j < h; j++) begin
            start = h - 1 - j;
            len   = m / 2 - h + 1 + 2 * j;
            g[j]  = (((s - start + m) % m) < len);
            g[j + h] = ~g[j];
        end
        return g;
    endfunction

    function automatic logic [7:0] exp_leg(input int leg, input int s, input bit five);
        int m;
        m = five ? 12 : 6;
        return exp_pat((s + m - leg * m / 3) % m, five);
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        m_restart = 0;
        m_step    = 0;
        if (!rst_n || !en) begin
            m_run = 0; m_cnt = 0; m_seg = 0;
        end else if (!m_run) begin
            m_run = 1; m_cnt = 0; m_seg = 0; m_restart = 1;
        end else if (m_cnt >= int'(div_val)) begin
            m_cnt = 0;
            m_seg = (m_seg + 1) % (five_lvl ? 12 : 6);
            m_step = 1;
        end else begin
            m_cnt++;
        end
    end

    always @(negedge clk) begin
        if (live && !done) begin
            if (!m_run) begin
                chk("R2 leg A off", gate_a, 8'h00);
                chk("R2 leg B off", gate_b, 8'h00);
                chk("R2 leg C off", gate_c, 8'h00);
                prev_lvl = -1;
            end else begin
                if (m_restart)   chk("R3 restart seg0", gate_a, exp_leg(0, 0, five_lvl));
                else if (m_step) chk("R4 segment advance", gate_a, exp_leg(0, m_seg, five_lvl));
                else if (five_lvl) chk("R5 five-level leg A", gate_a, exp_leg(0, m_seg, five_lvl));
                else             chk("R6 three-level leg A", gate_a, exp_leg(0, m_seg, five_lvl));
                chk("R10 leg B offset", gate_b, exp_leg(1, m_seg, five_lvl));
                chk("R10 leg C offset", gate_c, exp_leg(2, m_seg, five_lvl));
                chk("R7 half on", 8'($countones(gate_a)), five_lvl ? 8'd4 : 8'd2);
                if (!five_lvl)
                    chk("R8 no shoot-through", 8'(&gate_a[3:0]), 8'd0);
                begin
                    int lv;
                    lv = five_lvl ? $countones(gate_a[3:0]) : $countones(gate_a[1:0]);
                    if (prev_lvl >= 0)
                        chk("R9 single step", 8'((lv > prev_lvl) ? lv - prev_lvl : prev_lvl - lv) <= 8'd1 ? 8'd1 : 8'd0, 8'd1);
                    prev_lvl = lv;
                end
            end
        end
    end

    task automatic run_phase(input bit five, input int div, input int cyc);
        @(negedge clk);
        en = 1'b0;
        repeat (2) @(negedge clk);
        five_lvl = five;
        div_val  = DIV_W'(div);
        @(negedge clk);
        en = 1'b1;
        repeat (cyc) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk("R1 reset leg A", gate_a, 8'h00);
        chk("R1 reset leg B", gate_b, 8'h00);
        chk("R1 reset leg C", gate_c, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", gate_a | gate_b | gate_c, 8'h00);
        live = 1;

        // directed: fastest rate, both modes
        run_phase(1'b1, 0, 40);
        run_phase(1'b0, 0, 20);
        // directed: longer segments, disable mid-segment then restart
        run_phase(1'b1, 3, 30);
        en = 1'b0;
        repeat (3) @(negedge clk);
        en = 1'b1;
        repeat (60) @(negedge clk);
        run_phase(1'b0, 2, 50);
        // directed: shrink divider mid-run
        div_val = DIV_W'(9);
        repeat (25) @(negedge clk);
        div_val = DIV_W'(1);
        repeat (25) @(negedge clk);

        // constrained random phases
        for (int k = 0; k < 12; k++) begin
            bit f;
            int d, n;
            f = 1'($urandom_range(1, 0));
            d = int'($urandom_range(6, 0));
            n = int'($urandom_range(200, 20));
            run_phase(f, d, n);
            if ($urandom_range(1, 0) == 1) begin
                div_val = DIV_W'($urandom_range(6, 0));
                repeat (40) @(negedge clk);
            end
        end
        en = 1'b0;
        repeat (3) @(negedge clk);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL R4 watchdog expired: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule